// File: doc/BRIEF.md
# Interrupt Pacing Unit with Cause and Mask Registers

This block collects interrupt causes into a cause register, gates them with a mask register and decides when the interrupt line may rise. A time base advances on a clock-enable pulse, one pulse per 256 ns. A throttle interval, counted in those units, sets the smallest gap between two assertions of the line. The gap is measured from the last successful assertion, not from the arrival of a cause.

A cause strobe that comes in while the gap is still open arms one deferred post. That post fires when the gap has elapsed. An immediate flag skips the throttle for its strobe. A posting attempt finds either some unmasked cause or none. If it finds one, it raises the line, sets the asserted flag in the top bit of the cause register, restarts the gap and pulses a strobe that tells neighbouring delay timers to stand down. If it finds none, it changes nothing. A mask write that hides every cause drops any armed deferred post and lowers the line. A mask write that exposes a cause, with nothing armed, arms a deferred post one full interval ahead.

Top module: `irq_pacer`

## Requirements
- R1: Each strobe bit below the top bit is ORed into `cause_q`. The top bit of `cause_q` is the asserted flag and cannot be set by a strobe.
- R2: A non-zero strobe makes a posting attempt in its own cycle if any of these holds: `throttle_ival` is zero, `post_now` is high, or at least `throttle_ival` ticks have passed since the last successful post. Every count starts satisfied after reset.
- R3: Any other non-zero strobe arms a deferred post that fires when `throttle_ival` ticks have passed since the last successful post. A strobe that arrives while a deferred post is already armed leaves its firing time unchanged.
- R4: An attempt that finds no cause bit that is both set and unmasked leaves `irq`, `cancel_tmr` and the asserted flag untouched.
- R5: A successful attempt sets `irq` and the asserted flag, pulses `cancel_tmr` for one cycle, drops any armed deferred post and restarts the gap. All of these are visible one clock after the attempt.
- R6: A mask write that leaves no cause both set and unmasked drops any armed deferred post, lowers `irq` and clears the asserted flag.
- R7: A mask write that leaves a cause both set and unmasked, with no deferred post armed and no success in that cycle, arms a deferred post that fires `throttle_ival` ticks later.
- R8: `post_cnt` rises by one for every posting attempt, whether it is direct or deferred, and whether or not it succeeds.
- R9: When a mask write and a posting attempt fall in the same cycle, the written mask value decides whether the attempt succeeds.
- R10: After reset `irq`, `cancel_tmr`, `cause_q`, `mask_q` and `post_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_256ns | input | 1 | Time base enable, one pulse per 256 ns |
| cause_set | input | CAUSE_W | Cause strobes, top bit ignored |
| post_now | input | 1 | Skip the throttle for this cycle's strobe |
| mask_wr | input | 1 | Mask register write enable |
| mask_wdata | input | CAUSE_W | Mask value to write |
| throttle_ival | input | ITV_W | Minimum gap between posts, in ticks |
| irq | output | 1 | Interrupt line |
| cancel_tmr | output | 1 | One-cycle pulse on each successful post |
| cause_q | output | CAUSE_W | Cause register, top bit is the asserted flag |
| mask_q | output | CAUSE_W | Mask register |
| post_cnt | output | CNT_W | Count of posting attempts |

## Verification
A mask write and a posting attempt can land in the same cycle. The bench makes this happen by driving a strobe with `post_now` in the cycle of a mask write. In one case the written value hides every cause. In the other it exposes only the new cause. The first case must count the attempt and leave `irq` low with no `cancel_tmr` pulse. The second must post at once and must not also arm a deferred post, which the bench confirms by running several ticks afterwards and seeing `post_cnt` stay the same.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;

   // Per-cycle decision bundle shared by the pacing logic.
   typedef struct packed {
      logic attempt;   // a post is tried this cycle
      logic success;   // the try finds an unmasked cause
      logic quiet;     // mask write hides every cause
      logic arm;       // a deferred post is armed
      logic drop;      // the armed deferred post is discarded
   } pace_ctl_t;

endpackage

// File: rtl/irq_pacer_age.sv
module irq_pacer_age #(
   parameter int AGE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   output logic [AGE_W-1:0] age
);
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   // Saturating count of ticks since the last successful post.
   // Reset value is saturated, so the first cause is never held back.
   always_ff @(posedge clk) begin
      if (!rst_n)             age <= AGE_MAX;
      else if (restart)       age <= '0;
      else if (tick && age != AGE_MAX) age <= age + AGE_W'(1);
   end
endmodule

// File: rtl/irq_pacer_defer.sv
module irq_pacer_defer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             arm,
   input  logic [CNT_W-1:0] arm_val,
   input  logic             drop,
   output logic             pending,
   output logic             due
);
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] load_val;

   // A tick in the arming cycle already counts toward the wait.
   always_comb begin
      load_val = arm_val;
      if (tick && arm_val != '0) load_val = arm_val - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         remain  <= '0;
      end else if (drop) begin
         pending <= 1'b0;
      end else if (arm) begin
         pending <= 1'b1;
         remain  <= load_val;
      end else if (pending && tick && remain != '0) begin
         remain  <= remain - CNT_W'(1);
      end
   end

   assign due = pending && (remain == '0);

   assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && tick && remain != '0 && !drop && !arm) |=> (remain == $past(remain) - CNT_W'(1)));

   assert_drop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> !pending);
endmodule

// File: rtl/irq_pacer_regs.sv
module irq_pacer_regs #(
   parameter int CAUSE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] cause_set,
   input  logic               mask_wr,
   input  logic [CAUSE_W-1:0] mask_wdata,
   input  logic               flag_set,
   input  logic               flag_clr,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [CAUSE_W-1:0] mask_q
);
   localparam int FLAG_BIT = CAUSE_W - 1;

   // Sticky cause bits, one flop each.
   for (genvar b = 0; b < FLAG_BIT; b++) begin : g_cause
      always_ff @(posedge clk) begin
         if (!rst_n)          cause_q[b] <= 1'b0;
         else if (cause_set[b]) cause_q[b] <= 1'b1;
      end
   end

   // Asserted flag in the top bit.
   always_ff @(posedge clk) begin
      if (!rst_n)        cause_q[FLAG_BIT] <= 1'b0;
      else if (flag_set) cause_q[FLAG_BIT] <= 1'b1;
      else if (flag_clr) cause_q[FLAG_BIT] <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_wdata;
   end

   assert_flag_not_strobed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_set && !cause_q[FLAG_BIT]) |=> !cause_q[FLAG_BIT]);
endmodule

// File: rtl/irq_pacer.sv
module irq_pacer
   import irq_pacer_pkg::*;
#(
   parameter int CAUSE_W = 32,
   parameter int ITV_W   = 16,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_256ns,
   input  logic [CAUSE_W-1:0] cause_set,
   input  logic               post_now,
   input  logic               mask_wr,
   input  logic [CAUSE_W-1:0] mask_wdata,
   input  logic [ITV_W-1:0]   throttle_ival,
   output logic               irq,
   output logic               cancel_tmr,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [CAUSE_W-1:0] mask_q,
   output logic [CNT_W-1:0]   post_cnt
);
   localparam int FLAG_BIT = CAUSE_W - 1;
   localparam logic [CAUSE_W-1:0] SRC_BITS = {1'b0, {(CAUSE_W-1){1'b1}}};

   if (CAUSE_W < 2) begin : g_bad_cause_w
      $error("irq_pacer: CAUSE_W must leave room for the asserted flag");
   end
   if (ITV_W < 1 || CNT_W < 1) begin : g_bad_widths
      $error("irq_pacer: ITV_W and CNT_W must be positive");
   end

   logic [ITV_W-1:0]   age;
   logic               pending, due;
   logic [CAUSE_W-1:0] new_src, cause_nx, mask_eff;
   logic               hit, live, open_now, arm_cause, arm_mask;
   logic [ITV_W-1:0]   arm_val;
   pace_ctl_t          ctl;

   always_comb begin
      new_src   = cause_set & SRC_BITS;
      hit       = |new_src;
      cause_nx  = cause_q | new_src;
      mask_eff  = mask_wr ? mask_wdata : mask_q;
      live      = |(cause_nx & mask_eff & SRC_BITS);
      open_now  = (throttle_ival == '0) || post_now || (age >= throttle_ival);

      ctl.attempt = (hit && open_now) || due;
      ctl.success = ctl.attempt && live;
      ctl.quiet   = mask_wr && !live;
      arm_cause   = hit && !open_now && !pending;
      arm_mask    = mask_wr && live && !pending && !ctl.success;
      ctl.arm     = (arm_cause || arm_mask) && !ctl.quiet;
      ctl.drop    = ctl.success || ctl.quiet || due;
      arm_val     = arm_cause ? (throttle_ival - age) : throttle_ival;
   end

   irq_pacer_age #(.AGE_W(ITV_W)) i_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_256ns),
      .restart (ctl.success),
      .age     (age)
   );

   irq_pacer_defer #(.CNT_W(ITV_W)) i_defer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_256ns),
      .arm     (ctl.arm),
      .arm_val (arm_val),
      .drop    (ctl.drop),
      .pending (pending),
      .due     (due)
   );

   irq_pacer_regs #(.CAUSE_W(CAUSE_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cause_set  (new_src),
      .mask_wr    (mask_wr),
      .mask_wdata (mask_wdata),
      .flag_set   (ctl.success),
      .flag_clr   (ctl.quiet),
      .cause_q    (cause_q),
      .mask_q     (mask_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq        <= 1'b0;
         cancel_tmr <= 1'b0;
         post_cnt   <= '0;
      end else begin
         cancel_tmr <= ctl.success;
         if (ctl.success)    irq <= 1'b1;
         else if (ctl.quiet) irq <= 1'b0;
         if (ctl.attempt)    post_cnt <= post_cnt + CNT_W'(1);
      end
   end

   assert_cancel_with_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_tmr |-> (irq && cause_q[FLAG_BIT]));

   assert_cancel_restarts_age_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_tmr |-> (age == '0));

   assert_quiet_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.quiet |=> (!irq && !pending));

   assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.attempt && !live) |=> !cancel_tmr);

   assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.attempt |=> (post_cnt == $past(post_cnt) + CNT_W'(1)));
endmodule

// File: tb/test_irq_pacer.sv
module test_irq_pacer;
   localparam int CW = 32;
   localparam int IW = 16;
   localparam int NW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [CW-1:0] cause_set = '0;
   logic          post_now = 1'b0;
   logic          mask_wr = 1'b0;
   logic [CW-1:0] mask_wdata = '0;
   logic [IW-1:0] ival = '0;
   logic          irq, cancel_tmr;
   logic [CW-1:0] cause_q, mask_q;
   logic [NW-1:0] post_cnt;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;   // 125 MHz

   irq_pacer #(.CAUSE_W(CW), .ITV_W(IW), .CNT_W(NW)) i_irq_pacer (
      .clk(clk), .rst_n(rst_n), .tick_256ns(tick), .cause_set(cause_set),
      .post_now(post_now), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .throttle_ival(ival), .irq(irq), .cancel_tmr(cancel_tmr),
      .cause_q(cause_q), .mask_q(mask_q), .post_cnt(post_cnt)
   );

   typedef struct packed {
      logic       tk;
      logic [7:0] cs;
      logic       nw;
      logic       mw;
      logic [7:0] md;
      logic       ei;
      logic       ec;
      logic [7:0] en;
   } vec_t;

   // Interval 3 throughout the table.
   localparam vec_t TBL [0:18] = '{
      '{1'b0, 8'h00, 1'b0, 1'b1, 8'h0F, 1'b0, 1'b0, 8'd0},  // mask only
      '{1'b0, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'd1},  // R2 first post
      '{1'b1, 8'h02, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'd1},  // R3 early, armed
      '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'd1},
      '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'd1},
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'd2},  // R3 deferred fires
      '{1'b0, 8'h04, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'd3},  // R2 immediate flag
      '{1'b0, 8'h10, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'd3},  // armed again
      '{1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'd3},  // R6 mask hides all
      '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'd3},
      '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'd3},
      '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'd3},
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'd3},  // R6 dropped
      '{1'b0, 8'h00, 1'b0, 1'b1, 8'h10, 1'b0, 1'b0, 8'd3},  // R7 mask exposes
      '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'd3},
      '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'd3},
      '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'd3},
      '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'd4},  // R7 fires
      '{1'b0, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'd4}   // R3 early again
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic tk, input logic [CW-1:0] cs, input logic nw,
                        input logic mw, input logic [CW-1:0] md);
      tick = tk; cause_set = cs; post_now = nw; mask_wr = mw; mask_wdata = md;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0; cause_set = '0; post_now = 1'b0; mask_wr = 1'b0; mask_wdata = '0;
   endtask

   task automatic expect_out(input string req, input logic ei, input logic ec, input int en);
      check({req, " irq"}, 64'(irq), 64'(ei));
      check({req, " cancel"}, 64'(cancel_tmr), 64'(ec));
      check({req, " count"}, 64'(post_cnt), 64'(en));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      do_reset();
      // R10 reset state
      expect_out("R10", 1'b0, 1'b0, 0);
      check("R10 cause", 64'(cause_q), 64'h0);
      check("R10 mask", 64'(mask_q), 64'h0);

      ival = 16'd3;
      for (int i = 0; i < 19; i++) begin
         drive(TBL[i].tk, CW'(TBL[i].cs), TBL[i].nw, TBL[i].mw, CW'(TBL[i].md));
         expect_out($sformatf("table row %0d R2/R3/R6/R7", i), TBL[i].ei, TBL[i].ec, int'(TBL[i].en));
      end
      // R1 accumulated causes plus asserted flag
      check("R1 cause accumulate", 64'(cause_q), 64'h8000_0017);
      check("R1 mask value", 64'(mask_q), 64'h10);

      // Directed tests
      do_reset();
      ival = 16'd0;
      drive(1'b0, 32'h8000_0001, 1'b0, 1'b0, '0);
      expect_out("R4 masked attempt R8", 1'b0, 1'b0, 1);
      check("R1 top strobe ignored R4", 64'(cause_q), 64'h1);

      drive(1'b0, '0, 1'b0, 1'b1, 32'h1);
      expect_out("R7 zero interval arm", 1'b0, 1'b0, 1);
      drive(1'b0, '0, 1'b0, 1'b0, '0);
      expect_out("R7 zero interval fire R5", 1'b1, 1'b1, 2);
      drive(1'b0, '0, 1'b0, 1'b0, '0);
      expect_out("R5 single pulse", 1'b1, 1'b0, 2);
      drive(1'b0, 32'h1, 1'b0, 1'b0, '0);
      expect_out("R2 zero interval", 1'b1, 1'b1, 3);

      // Boundary of the gap, interval 3
      ival = 16'd3;
      drive(1'b1, '0, 1'b0, 1'b0, '0);
      drive(1'b1, '0, 1'b0, 1'b0, '0);
      drive(1'b0, 32'h2, 1'b0, 1'b0, '0);
      expect_out("R3 two ticks early", 1'b1, 1'b0, 3);
      drive(1'b1, '0, 1'b0, 1'b0, '0);
      expect_out("R3 waiting", 1'b1, 1'b0, 3);
      drive(1'b0, '0, 1'b0, 1'b0, '0);
      expect_out("R3 remaining tick fires", 1'b1, 1'b1, 4);
      repeat (3) drive(1'b1, '0, 1'b0, 1'b0, '0);
      drive(1'b0, 32'h1, 1'b0, 1'b0, '0);
      expect_out("R2 gap exactly met", 1'b1, 1'b1, 5);

      // An early strobe must not re-time a mask-armed deferred post
      drive(1'b1, '0, 1'b0, 1'b0, '0);
      drive(1'b0, '0, 1'b0, 1'b1, 32'h1);
      drive(1'b0, 32'h2, 1'b0, 1'b0, '0);
      drive(1'b1, '0, 1'b0, 1'b0, '0);
      drive(1'b1, '0, 1'b0, 1'b0, '0);
      drive(1'b0, '0, 1'b0, 1'b0, '0);
      expect_out("R3 no restart while armed", 1'b1, 1'b0, 5);
      drive(1'b1, '0, 1'b0, 1'b0, '0);
      drive(1'b0, '0, 1'b0, 1'b0, '0);
      expect_out("R3 original target fires", 1'b1, 1'b1, 6);

      // Mask write colliding with an attempt
      drive(1'b0, 32'h1, 1'b1, 1'b1, 32'h0);
      expect_out("R9 new mask hides R6", 1'b0, 1'b0, 7);
      check("R6 flag cleared", 64'(cause_q[CW-1]), 64'h0);
      drive(1'b0, 32'h40, 1'b1, 1'b1, 32'h40);
      expect_out("R9 new mask exposes", 1'b1, 1'b1, 8);
      repeat (4) drive(1'b1, '0, 1'b0, 1'b0, '0);
      drive(1'b0, '0, 1'b0, 1'b0, '0);
      expect_out("R9 no extra arm", 1'b1, 1'b0, 8);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule